// File: doc/BRIEF.md
# Open-Row Write Command Scheduler

This block turns single write requests into command sequences for an SDRAM command bus. A requester offers a bank, a row, a column and a flag. The flag says whether the request continues a sequential burst. The scheduler keeps a table of the row held open in each bank and uses it to choose one of three sequences. It can issue a write on its own. It can issue an activate and then a write. It can issue a precharge, then an activate, then a write.

Spacing between commands comes from two small configuration inputs. One sets the gap from precharge to activate and the other sets the gap from activate to write. Idle cycles are filled with no-operation codes. The requester sees a ready signal that is high only while the scheduler is idle. A request is taken on a clock edge where both valid and ready are high.

Top module: `wrsched_top`

## Requirements
- R1: After reset, `req_ready` is 1, `cmd_code` is NOP, and every bank is marked closed, so the first write to any bank issues ACTIVATE with no PRECHARGE before it.
- R2: A sequential request (`req_seq`=1) whose row matches the open row of its bank issues only WRITE, in the cycle right after acceptance.
- R3: A request to a bank that is open on a different row issues PRECHARGE in the cycle after acceptance, then ACTIVATE for the new row, then WRITE.
- R4: Open rows are tracked per bank. A request to a closed bank issues ACTIVATE then WRITE and leaves the open rows of other banks in place.
- R5: A non-sequential request (`req_seq`=0) to an open bank always issues PRECHARGE, ACTIVATE and WRITE, even when its row is the open row.
- R6: ACTIVATE follows PRECHARGE after exactly max(`cfg_trp`,1) cycles, with NOP in every cycle between them.
- R7: WRITE follows ACTIVATE after exactly max(`cfg_trcd`,1) cycles, with NOP in every cycle between them.
- R8: `cmd_code` uses these codes: 0 = NOP, 1 = PRECHARGE, 2 = ACTIVATE, 3 = WRITE. A PRECHARGE carries the bank on `cmd_bank`. An ACTIVATE carries the bank and the row on `cmd_bank` and `cmd_row`. A WRITE carries the bank and the column on `cmd_bank` and `cmd_col`.
- R9: `req_ready` is 1 only while the scheduler is idle, and the idle scheduler issues NOP. The request fields are captured at acceptance. A request held valid while the scheduler is busy is ignored, and changing the fields during that time has no effect on the commands.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_trp | input | 4 | Cycles from precharge to activate |
| cfg_trcd | input | 4 | Cycles from activate to write |
| req_valid | input | 1 | A write request is offered |
| req_ready | output | 1 | The scheduler is idle and will accept |
| req_seq | input | 1 | The request continues a sequential burst |
| req_bank | input | 2 | Target bank |
| req_row | input | 13 | Target row |
| req_col | input | 10 | Target column |
| cmd_code | output | 2 | Command code: NOP, PRECHARGE, ACTIVATE, WRITE |
| cmd_bank | output | 2 | Bank field of the command |
| cmd_row | output | 13 | Row field of the command |
| cmd_col | output | 10 | Column field of the command |

## Verification
The bench aims at the three edges of the decision:
- A non-sequential request to the row that is already open. A design that trusted the row match here would issue a bare WRITE.
- A first touch of a closed bank. A design that precharged it anyway would emit a stray PRECHARGE.
- A return to a bank after another bank was used. A design that kept a single shared row register would cycle the row again.

The spacing counters are swept across 0, 1, 2 and 15. An off-by-one error would move ACTIVATE or WRITE by a cycle, and mishandling 0 would produce a zero or wrapped-around wait. Requests are held valid while the scheduler is busy and their fields are scrambled during that time. Any late capture would show up as a wrong row or column, or as a second sequence.

// File: rtl/wrsched_pkg.sv
package wrsched_pkg;

  typedef enum logic [1:0] {
    CMD_NOP = 2'd0,
    CMD_PRE = 2'd1,
    CMD_ACT = 2'd2,
    CMD_WR  = 2'd3
  } cmd_e;

  typedef enum logic [2:0] {
    S_IDLE,
    S_PRE,
    S_WAIT_RP,
    S_ACT,
    S_WAIT_RCD,
    S_WR
  } sched_state_e;

  // spacing in cycles; settings 0 and 1 both mean "next cycle"
  function automatic logic [3:0] gap_of(input logic [3:0] setting);
    return (setting < 4'd2) ? 4'd1 : setting;
  endfunction

endpackage

// File: rtl/wrsched_rowtrack.sv
module wrsched_rowtrack #(
  parameter int NBANK  = 4,
  parameter int ROW_W  = 13,
  parameter int BANK_W = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [BANK_W-1:0] look_bank,
  input  logic [ROW_W-1:0]  look_row,
  input  logic              upd_close,
  input  logic              upd_open,
  input  logic [BANK_W-1:0] upd_bank,
  input  logic [ROW_W-1:0]  upd_row,
  output logic              bank_open,
  output logic              row_hit
);

  logic [NBANK-1:0] vld;
  logic [ROW_W-1:0] rows [NBANK];

  for (genvar g = 0; g < NBANK; g++) begin : g_bank
    always_ff @(posedge clk) begin
      if (!rst_n) begin
        vld[g]  <= 1'b0;
        rows[g] <= '0;
      end else if (upd_open && upd_bank == BANK_W'(g)) begin
        vld[g]  <= 1'b1;
        rows[g] <= upd_row;
      end else if (upd_close && upd_bank == BANK_W'(g)) begin
        vld[g]  <= 1'b0;
      end
    end
  end

  always_comb begin
    bank_open = vld[look_bank];
    row_hit   = bank_open && (rows[look_bank] == look_row);
  end

endmodule

// File: rtl/wrsched_gap.sv
module wrsched_gap #(
  parameter int CNT_W = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load,
  input  logic [CNT_W-1:0] load_val,
  output logic             last
);

  logic [CNT_W-1:0] cnt;

  always_ff @(posedge clk) begin
    if (!rst_n)          cnt <= '0;
    else if (load)       cnt <= load_val;
    else if (cnt != '0)  cnt <= cnt - 1'b1;
  end

  assign last = (cnt <= CNT_W'(1));

endmodule

// File: rtl/wrsched_fsm.sv
module wrsched_fsm
  import wrsched_pkg::*;
(
  input  logic         clk,
  input  logic         rst_n,
  input  logic [3:0]   cfg_trp,
  input  logic [3:0]   cfg_trcd,
  input  logic         req_valid,
  input  logic         req_seq,
  input  logic         row_hit,
  input  logic         bank_open,
  input  logic         gap_last,
  output logic         gap_load,
  output logic [3:0]   gap_val,
  output logic         accept,
  output logic         idle,
  output cmd_e         cmd
);

  sched_state_e st, st_nx;
  logic [3:0] rp_gap, rcd_gap;

  assign rp_gap  = gap_of(cfg_trp);
  assign rcd_gap = gap_of(cfg_trcd);
  assign idle    = (st == S_IDLE);
  assign accept  = idle && req_valid;

  always_comb begin
    st_nx    = st;
    gap_load = 1'b0;
    gap_val  = '0;
    cmd      = CMD_NOP;
    unique case (st)
      S_IDLE: begin
        if (req_valid) begin
          if (req_seq && row_hit) st_nx = S_WR;
          else if (bank_open)     st_nx = S_PRE;
          else                    st_nx = S_ACT;
        end
      end
      S_PRE: begin
        cmd      = CMD_PRE;
        gap_load = 1'b1;
        gap_val  = rp_gap - 4'd1;
        st_nx    = (rp_gap == 4'd1) ? S_ACT : S_WAIT_RP;
      end
      S_WAIT_RP: begin
        if (gap_last) st_nx = S_ACT;
      end
      S_ACT: begin
        cmd      = CMD_ACT;
        gap_load = 1'b1;
        gap_val  = rcd_gap - 4'd1;
        st_nx    = (rcd_gap == 4'd1) ? S_WR : S_WAIT_RCD;
      end
      S_WAIT_RCD: begin
        if (gap_last) st_nx = S_WR;
      end
      S_WR: begin
        cmd   = CMD_WR;
        st_nx = S_IDLE;
      end
      default: st_nx = S_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) st <= S_IDLE;
    else        st <= st_nx;
  end

endmodule

// File: rtl/wrsched_top.sv
module wrsched_top
  import wrsched_pkg::*;
#(
  parameter int NBANK = 4,
  parameter int ROW_W = 13,
  parameter int COL_W = 10,
  localparam int BANK_W = $clog2(NBANK)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [3:0]        cfg_trp,
  input  logic [3:0]        cfg_trcd,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic              req_seq,
  input  logic [BANK_W-1:0] req_bank,
  input  logic [ROW_W-1:0]  req_row,
  input  logic [COL_W-1:0]  req_col,
  output logic [1:0]        cmd_code,
  output logic [BANK_W-1:0] cmd_bank,
  output logic [ROW_W-1:0]  cmd_row,
  output logic [COL_W-1:0]  cmd_col
);

  // named internal events, observed by the bound checker
  logic row_hit, bank_open, accept, idle;
  logic ev_pre, ev_act;
  logic gap_load, gap_last;
  logic [3:0] gap_val;
  cmd_e cmd;

  logic [BANK_W-1:0] lat_bank;
  logic [ROW_W-1:0]  lat_row;
  logic [COL_W-1:0]  lat_col;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      lat_bank <= '0;
      lat_row  <= '0;
      lat_col  <= '0;
    end else if (accept) begin
      lat_bank <= req_bank;
      lat_row  <= req_row;
      lat_col  <= req_col;
    end
  end

  assign ev_pre = (cmd == CMD_PRE);
  assign ev_act = (cmd == CMD_ACT);

  wrsched_rowtrack #(.NBANK(NBANK), .ROW_W(ROW_W), .BANK_W(BANK_W)) track_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .look_bank (req_bank),
    .look_row  (req_row),
    .upd_close (ev_pre),
    .upd_open  (ev_act),
    .upd_bank  (lat_bank),
    .upd_row   (lat_row),
    .bank_open (bank_open),
    .row_hit   (row_hit)
  );

  wrsched_gap #(.CNT_W(4)) gap_i (
    .clk      (clk),
    .rst_n    (rst_n),
    .load     (gap_load),
    .load_val (gap_val),
    .last     (gap_last)
  );

  wrsched_fsm fsm_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .cfg_trp   (cfg_trp),
    .cfg_trcd  (cfg_trcd),
    .req_valid (req_valid),
    .req_seq   (req_seq),
    .row_hit   (row_hit),
    .bank_open (bank_open),
    .gap_last  (gap_last),
    .gap_load  (gap_load),
    .gap_val   (gap_val),
    .accept    (accept),
    .idle      (idle),
    .cmd       (cmd)
  );

  assign req_ready = idle;
  assign cmd_code  = cmd;
  assign cmd_bank  = lat_bank;
  assign cmd_row   = lat_row;
  assign cmd_col   = lat_col;

endmodule

// File: rtl/wrsched_chk.sv
module wrsched_chk
  import wrsched_pkg::*;
(
  input logic       clk,
  input logic       rst_n,
  input logic [3:0] cfg_trp,
  input logic [3:0] cfg_trcd,
  input logic       req_valid,
  input logic       req_ready,
  input logic       req_seq,
  input logic       row_hit,
  input logic [1:0] cmd_code
);

  logic [4:0] since_pre, since_act;
  logic       pend_pre, pend_act;
  logic [4:0] need_rp, need_rcd;

  assign need_rp  = (cfg_trp  == 4'd0) ? 5'd1 : {1'b0, cfg_trp};
  assign need_rcd = (cfg_trcd == 4'd0) ? 5'd1 : {1'b0, cfg_trcd};

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      since_pre <= '0; since_act <= '0;
      pend_pre  <= 1'b0; pend_act <= 1'b0;
    end else begin
      if (cmd_code == CMD_PRE) begin since_pre <= 5'd1; pend_pre <= 1'b1; end
      else if (since_pre != 5'd31) since_pre <= since_pre + 5'd1;
      if (cmd_code == CMD_ACT) begin
        since_act <= 5'd1; pend_act <= 1'b1; pend_pre <= 1'b0;
      end else if (since_act != 5'd31) since_act <= since_act + 5'd1;
      if (cmd_code == CMD_WR) pend_act <= 1'b0;
    end
  end

  // R6
  act_spacing_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_code == CMD_ACT && pend_pre) |-> since_pre == need_rp);

  // R7
  wr_spacing_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_code == CMD_WR && pend_act) |-> since_act == need_rcd);

  // R9
  idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    req_ready |-> cmd_code == CMD_NOP);

  // R9
  busy_after_accept_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_ready) |=> !req_ready);

  // R2
  hit_write_now_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_ready && req_seq && row_hit) |=> cmd_code == CMD_WR);

  // R5
  nonseq_no_bare_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_ready && !req_seq) |=> cmd_code != CMD_WR);

  // R3
  pre_not_then_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_code == CMD_PRE) |=> cmd_code != CMD_WR);

endmodule

bind wrsched_top wrsched_chk chk_i (
  .clk       (clk),
  .rst_n     (rst_n),
  .cfg_trp   (cfg_trp),
  .cfg_trcd  (cfg_trcd),
  .req_valid (req_valid),
  .req_ready (req_ready),
  .req_seq   (req_seq),
  .row_hit   (row_hit),
  .cmd_code  (cmd_code)
);

// File: tb/wrsched_tb.sv
module wrsched_top_tb_top;

  localparam int C_NOP = 0, C_PRE = 1, C_ACT = 2, C_WR = 3;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [3:0]  cfg_trp = 4'd2, cfg_trcd = 4'd2;
  logic        req_valid = 1'b0, req_seq = 1'b0;
  logic        req_ready;
  logic [1:0]  req_bank = '0;
  logic [12:0] req_row = '0;
  logic [9:0]  req_col = '0;
  logic [1:0]  cmd_code, cmd_bank;
  logic [12:0] cmd_row;
  logic [9:0]  cmd_col;

  int n_chk = 0, n_bad = 0;
  bit m_open [4];
  int m_row  [4];
  int exp_q  [64];
  int exp_n;

  always #4 clk = ~clk;

  wrsched_top dut_i (
    .clk(clk), .rst_n(rst_n), .cfg_trp(cfg_trp), .cfg_trcd(cfg_trcd),
    .req_valid(req_valid), .req_ready(req_ready), .req_seq(req_seq),
    .req_bank(req_bank), .req_row(req_row), .req_col(req_col),
    .cmd_code(cmd_code), .cmd_bank(cmd_bank), .cmd_row(cmd_row), .cmd_col(cmd_col)
  );

  task automatic check(input string tag, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s: got %0d expected %0d", tag, act, exp);
    end
  endtask

  function automatic int spacing(input int t);
    return (t == 0) ? 1 : t;
  endfunction

  task automatic push_gap(input int cmdv, input int t);
    exp_q[exp_n++] = cmdv;
    for (int k = 1; k < spacing(t); k++) exp_q[exp_n++] = C_NOP;
  endtask

  // one write request; caller sits at a negedge with the scheduler idle
  task automatic run_req(input string tag, input int b, input int r, input int c,
                         input bit seq, input int trp, input int trcd, input bit hold_busy);
    exp_n = 0;
    if (!(seq && m_open[b] && m_row[b] == r)) begin
      if (m_open[b]) push_gap(C_PRE, trp);
      push_gap(C_ACT, trcd);
    end
    exp_q[exp_n++] = C_WR;
    cfg_trp = 4'(trp); cfg_trcd = 4'(trcd);
    check({tag, " R9 ready idle"}, int'(req_ready), 1);
    check({tag, " R9 idle nop"}, int'(cmd_code), C_NOP);
    req_valid = 1'b1; req_seq = seq;
    req_bank = 2'(b); req_row = 13'(r); req_col = 10'(c);
    @(negedge clk);
    if (hold_busy) begin
      req_bank = 2'(b + 1); req_row = 13'(r + 77); req_col = 10'(c + 5); req_seq = ~seq;
    end else req_valid = 1'b0;
    for (int i = 0; i < exp_n; i++) begin
      check({tag, " R8 code"}, int'(cmd_code), exp_q[i]);
      check({tag, " R9 busy"}, int'(req_ready), 0);
      if (exp_q[i] != C_NOP) check({tag, " R8 bank"}, int'(cmd_bank), b);
      if (exp_q[i] == C_ACT) check({tag, " R8 row"}, int'(cmd_row), r);
      if (exp_q[i] == C_WR)  check({tag, " R8 col"}, int'(cmd_col), c);
      if (i == exp_n - 1) req_valid = 1'b0;
      @(negedge clk);
    end
    m_open[b] = 1'b1; m_row[b] = r;
    check({tag, " R9 ready again"}, int'(req_ready), 1);
    check({tag, " R9 nop again"}, int'(cmd_code), C_NOP);
  endtask

  task automatic t_reset();
    check("R1 ready", int'(req_ready), 1);
    check("R1 nop", int'(cmd_code), C_NOP);
    run_req("R1 first act", 0, 100, 8, 1'b1, 2, 2, 1'b0);
  endtask

  task automatic t_hit();
    run_req("R2 seq hit", 0, 100, 16, 1'b1, 2, 2, 1'b0);
    check("R2 length", exp_n, 1);
  endtask

  task automatic t_row_miss();
    run_req("R3 row miss", 0, 200, 24, 1'b1, 3, 2, 1'b0);
  endtask

  task automatic t_other_bank();
    run_req("R4 closed bank", 2, 55, 3, 1'b0, 2, 3, 1'b0);
    run_req("R4 bank0 kept", 0, 200, 40, 1'b1, 2, 2, 1'b0);
    check("R4 bank0 hit len", exp_n, 1);
    run_req("R4 bank2 kept", 2, 55, 9, 1'b1, 2, 2, 1'b0);
    check("R4 bank2 hit len", exp_n, 1);
  endtask

  task automatic t_nonseq();
    run_req("R5 nonseq same row", 0, 200, 48, 1'b0, 2, 2, 1'b0);
    check("R5 length", exp_n, 5);
  endtask

  task automatic t_trp();
    run_req("R6 trp0", 1, 1, 1, 1'b1, 0, 1, 1'b0);
    run_req("R6 trp0 miss", 1, 2, 1, 1'b1, 0, 1, 1'b0);
    run_req("R6 trp1", 1, 3, 2, 1'b1, 1, 1, 1'b0);
    run_req("R6 trp2", 1, 4, 3, 1'b1, 2, 1, 1'b0);
    run_req("R6 trp15", 1, 5, 4, 1'b1, 15, 1, 1'b0);
  endtask

  task automatic t_trcd();
    run_req("R7 trcd0", 3, 9, 1, 1'b1, 1, 0, 1'b0);
    run_req("R7 trcd1", 3, 10, 2, 1'b1, 1, 1, 1'b0);
    run_req("R7 trcd7", 3, 11, 3, 1'b1, 1, 7, 1'b0);
    run_req("R7 trcd15", 3, 12, 4, 1'b1, 2, 15, 1'b0);
  endtask

  task automatic t_busy();
    run_req("R9 held busy miss", 3, 300, 7, 1'b0, 3, 3, 1'b1);
    run_req("R9 held busy hit", 3, 300, 11, 1'b1, 2, 2, 1'b1);
    check("R9 hit len", exp_n, 1);
  endtask

  initial begin
    for (int i = 0; i < 4; i++) begin m_open[i] = 1'b0; m_row[i] = 0; end
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_hit();
    t_row_miss();
    t_other_bank();
    t_nonseq();
    t_trp();
    t_trcd();
    t_busy();
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    n_chk++; n_bad++;
    $display("FAIL watchdog: got 1 expected 0");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

endmodule